// File: doc/BRIEF.md
# Memory Map Bulk Loader

The loader fills one of three on-chip translation tables from a run of consecutive memory words. The tables hold write-lock codes, access-control codes and physical page relocation values. A single start pulse supplies a map selector, a word pointer, a starting table index and a word count. The block then fetches one word at a time over a simple request/acknowledge read port and unpacks it into a fixed number of equal-width items, writing each item to the table at a running index that wraps around the table.

Unpacking is done by rotating the fetched word left by the item width before every item and keeping the low bits of the result under a per-map mask, so the most significant field of the word lands first. After every complete word the pointer, index and remaining count are published, so a caller that is interrupted by a read fault can resume from the last finished word. A selector that names no table, or a table whose model option is switched off, is refused with a trap and nothing is written.

Top module: `mbl_loader`

## Requirements
- R1: Selectors 1, 2 and 4 are always accepted; selector 3 only when `opt_lock4` is 1 and selector 5 only when `opt_wide` is 1. Any other selector (0, 6, 7, or 3/5 with its option off) raises `trap` for one cycle, one cycle after `start`, leaves `busy` low and writes no table entry.
- R2: Item formats: selector 1 writes 2-bit values into the lock table, 2 writes 2-bit values into the access table, 3 writes 4-bit values into the lock table, 4 writes 8-bit values into the relocation table, 5 writes 16-bit fields masked to their low 11 bits into the relocation table. Each word yields 32 / width items.
- R3: Before each item the working word is rotated left by the item width and the item is taken from its low bits, so the first item of a word is its most significant field (word 0x12345678 under selector 4 gives 0x12, 0x34, 0x56, 0x78).
- R4: The starting index is masked to the selected table's depth minus one, and after every item the index advances by one modulo the table depth (lock 32, access 32, relocation 64 entries by default).
- R5: After every complete word `wb_valid` pulses for one cycle with `wb_ptr` one above its previous value, `wb_cnt` one below it and `wb_idx` equal to the index of the next item.
- R6: When the count reaches zero `done` pulses for one cycle and `busy` drops in that cycle; a starting count of 0 loads 2^CNT_W words. At most one of `done`, `fault` and `trap` is high in any cycle.
- R7: A read answered with `mem_err` ends the load: no item of that word is written, `fault` pulses, `busy` drops, and pointer, index and count keep the values of the last complete word.
- R8: `busy` is high from the cycle after an accepted start until the load ends; `mem_req` is only high while busy; `start` while busy is ignored.
- R9: After reset `busy`, `done`, `fault`, `trap` and `wb_valid` are low, the published pointer, index and count are zero and every table entry reads zero.
- R10: Once raised, `mem_req` stays high with `mem_addr` equal to the current pointer and unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| map_sel | input | 3 | Map selector |
| opt_lock4 | input | 1 | Enables selector 3 |
| opt_wide | input | 1 | Enables selector 5 |
| ptr_in | input | PTR_W | First word address |
| idx_in | input | IDX_W | First table index |
| cnt_in | input | CNT_W | Number of words (0 means 2^CNT_W) |
| mem_req | output | 1 | Read request |
| mem_addr | output | PTR_W | Read word address |
| mem_ack | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read fault, qualified by mem_ack |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completed pulse |
| fault | output | 1 | Load aborted by read fault pulse |
| trap | output | 1 | Invalid selector pulse |
| wb_valid | output | 1 | Per-word write-back pulse |
| wb_ptr | output | PTR_W | Current word pointer |
| wb_idx | output | IDX_W | Current table index |
| wb_cnt | output | CNT_W | Remaining word count |
| rd_idx | input | IDX_W | Table read index |
| rd_wlk | output | 4 | Lock table entry at rd_idx |
| rd_acc | output | 2 | Access table entry at rd_idx |
| rd_rel | output | 11 | Relocation table entry at rd_idx |

## Verification
Random loads over all five valid selectors with random pointers, start indices, word counts and random read latency tell apart item width, field order and table choice, since each selector's output differs from every other's on the same random memory image. Directed words with known fields separate a left from a right rotation, start indices at and beyond the table depth separate a modulo wrap from a saturating or unmasked index, and a zero count separates the full-range load from an immediate finish. Faults on the first and on a later word, refused selectors and a start pulse during a load show that nothing past the last complete word is touched.

// File: rtl/mbl_pkg.sv
package mbl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_UNPACK = 2'd2
    } mbl_state_e;

    typedef enum logic [1:0] {
        TGT_LOCK  = 2'd0,
        TGT_ACC   = 2'd1,
        TGT_RELOC = 2'd2
    } mbl_target_e;

    localparam int ITEM_MAX_W = 11;

    typedef struct packed {
        logic                  ok;
        mbl_target_e           tgt;
        logic [4:0]            width;
        logic [ITEM_MAX_W-1:0] dmask;
        logic [3:0]            last_item;
    } mbl_cfg_t;

endpackage

// File: rtl/mbl_decode.sv
module mbl_decode
    import mbl_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       opt_lock4,
    input  logic       opt_wide,
    output mbl_cfg_t   cfg
);
    always_comb begin
        cfg = '{ok: 1'b0, tgt: TGT_LOCK, width: 5'd2, dmask: '0, last_item: 4'd15};
        unique case (sel)
            3'd1: cfg = '{ok: 1'b1, tgt: TGT_LOCK, width: 5'd2,
                          dmask: 11'h003, last_item: 4'd15};
            3'd2: cfg = '{ok: 1'b1, tgt: TGT_ACC, width: 5'd2,
                          dmask: 11'h003, last_item: 4'd15};
            3'd3: cfg = '{ok: opt_lock4, tgt: TGT_LOCK, width: 5'd4,
                          dmask: 11'h00F, last_item: 4'd7};
            3'd4: cfg = '{ok: 1'b1, tgt: TGT_RELOC, width: 5'd8,
                          dmask: 11'h0FF, last_item: 4'd3};
            3'd5: cfg = '{ok: opt_wide, tgt: TGT_RELOC, width: 5'd16,
                          dmask: 11'h7FF, last_item: 4'd1};
            default: cfg.ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/mbl_unpack.sv
module mbl_unpack
    import mbl_pkg::*;
(
    input  logic [31:0]            word,
    input  logic [4:0]             width,
    input  logic [ITEM_MAX_W-1:0]  dmask,
    output logic [31:0]            rotated,
    output logic [ITEM_MAX_W-1:0]  item
);
    always_comb begin
        unique case (width)
            5'd2:    rotated = {word[29:0], word[31:30]};
            5'd4:    rotated = {word[27:0], word[31:28]};
            5'd8:    rotated = {word[23:0], word[31:24]};
            5'd16:   rotated = {word[15:0], word[31:16]};
            default: rotated = word;
        endcase
        item = rotated[ITEM_MAX_W-1:0] & dmask;
    end
endmodule

// File: rtl/mbl_map_array.sv
module mbl_map_array #(
    parameter int DEPTH = 32,
    parameter int DW    = 4,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (we && (waddr == IW'(g))) begin
                mem_q[g] <= wdata;
            end
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/mbl_loader.sv
module mbl_loader
    import mbl_pkg::*;
#(
    parameter int PTR_W     = 16,
    parameter int CNT_W     = 8,
    parameter int LOCK_DEPTH  = 32,
    parameter int ACC_DEPTH   = 32,
    parameter int RELOC_DEPTH = 64,
    localparam int LOCK_IW  = $clog2(LOCK_DEPTH),
    localparam int ACC_IW   = $clog2(ACC_DEPTH),
    localparam int RELOC_IW = $clog2(RELOC_DEPTH),
    localparam int IDX_W    = (LOCK_IW > ACC_IW)
                              ? ((LOCK_IW > RELOC_IW) ? LOCK_IW : RELOC_IW)
                              : ((ACC_IW > RELOC_IW) ? ACC_IW : RELOC_IW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       map_sel,
    input  logic             opt_lock4,
    input  logic             opt_wide,
    input  logic [PTR_W-1:0] ptr_in,
    input  logic [IDX_W-1:0] idx_in,
    input  logic [CNT_W-1:0] cnt_in,
    output logic             mem_req,
    output logic [PTR_W-1:0] mem_addr,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_err,
    output logic             busy,
    output logic             done,
    output logic             fault,
    output logic             trap,
    output logic             wb_valid,
    output logic [PTR_W-1:0] wb_ptr,
    output logic [IDX_W-1:0] wb_idx,
    output logic [CNT_W-1:0] wb_cnt,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [3:0]       rd_wlk,
    output logic [1:0]       rd_acc,
    output logic [10:0]      rd_rel
);
    localparam logic [IDX_W-1:0] LOCK_MASK  = IDX_W'(LOCK_DEPTH - 1);
    localparam logic [IDX_W-1:0] ACC_MASK   = IDX_W'(ACC_DEPTH - 1);
    localparam logic [IDX_W-1:0] RELOC_MASK = IDX_W'(RELOC_DEPTH - 1);

    typedef struct packed {
        mbl_state_e         state;
        mbl_cfg_t           cfg;
        logic [PTR_W-1:0]   ptr;
        logic [IDX_W-1:0]   idx;
        logic [CNT_W-1:0]   cnt;
        logic [31:0]        word;
        logic [3:0]         item;
        logic               done;
        logic               fault;
        logic               trap;
        logic               wbv;
    } regs_t;

    regs_t r_q, r_d;

    mbl_cfg_t              cfg_new;
    logic [31:0]           rot;
    logic [ITEM_MAX_W-1:0] item_val;
    logic                  we_lock, we_acc, we_reloc;

    function automatic logic [IDX_W-1:0] idx_mask(input mbl_target_e t);
        unique case (t)
            TGT_LOCK:  return LOCK_MASK;
            TGT_ACC:   return ACC_MASK;
            default:   return RELOC_MASK;
        endcase
    endfunction

    mbl_decode u_decode (
        .sel       (map_sel),
        .opt_lock4 (opt_lock4),
        .opt_wide  (opt_wide),
        .cfg       (cfg_new)
    );

    mbl_unpack u_unpack (
        .word    (r_q.word),
        .width   (r_q.cfg.width),
        .dmask   (r_q.cfg.dmask),
        .rotated (rot),
        .item    (item_val)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        r_d.trap  = 1'b0;
        r_d.wbv   = 1'b0;
        we_lock   = 1'b0;
        we_acc    = 1'b0;
        we_reloc  = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (cfg_new.ok) begin
                        r_d.cfg   = cfg_new;
                        r_d.ptr   = ptr_in;
                        r_d.idx   = idx_in & idx_mask(cfg_new.tgt);
                        r_d.cnt   = cnt_in;
                        r_d.state = ST_FETCH;
                    end else begin
                        r_d.trap = 1'b1;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    if (mem_err) begin
                        r_d.fault = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.word  = mem_rdata;
                        r_d.item  = '0;
                        r_d.state = ST_UNPACK;
                    end
                end
            end
            ST_UNPACK: begin
                we_lock  = (r_q.cfg.tgt == TGT_LOCK);
                we_acc   = (r_q.cfg.tgt == TGT_ACC);
                we_reloc = (r_q.cfg.tgt == TGT_RELOC);
                r_d.word = rot;
                r_d.idx  = (r_q.idx + 1'b1) & idx_mask(r_q.cfg.tgt);
                r_d.item = r_q.item + 1'b1;
                if (r_q.item == r_q.cfg.last_item) begin
                    r_d.ptr = r_q.ptr + 1'b1;
                    r_d.cnt = r_q.cnt - 1'b1;
                    r_d.wbv = 1'b1;
                    if (r_q.cnt == CNT_W'(1)) begin
                        r_d.done  = 1'b1;
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.state = ST_FETCH;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    mbl_map_array #(.DEPTH(LOCK_DEPTH), .DW(4)) u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_lock),
        .waddr (r_q.idx[LOCK_IW-1:0]),
        .wdata (item_val[3:0]),
        .raddr (rd_idx[LOCK_IW-1:0]),
        .rdata (rd_wlk)
    );

    mbl_map_array #(.DEPTH(ACC_DEPTH), .DW(2)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_acc),
        .waddr (r_q.idx[ACC_IW-1:0]),
        .wdata (item_val[1:0]),
        .raddr (rd_idx[ACC_IW-1:0]),
        .rdata (rd_acc)
    );

    mbl_map_array #(.DEPTH(RELOC_DEPTH), .DW(11)) u_reloc (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_reloc),
        .waddr (r_q.idx[RELOC_IW-1:0]),
        .wdata (item_val),
        .raddr (rd_idx[RELOC_IW-1:0]),
        .rdata (rd_rel)
    );

    assign mem_req  = (r_q.state == ST_FETCH);
    assign mem_addr = r_q.ptr;
    assign busy     = (r_q.state != ST_IDLE);
    assign done     = r_q.done;
    assign fault    = r_q.fault;
    assign trap     = r_q.trap;
    assign wb_valid = r_q.wbv;
    assign wb_ptr   = r_q.ptr;
    assign wb_idx   = r_q.idx;
    assign wb_cnt   = r_q.cnt;
endmodule

// File: rtl/mbl_loader_chk.sv
module mbl_loader_chk #(
    parameter int PTR_W = 16,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_ack,
    input logic [PTR_W-1:0] mem_addr,
    input logic             done,
    input logic             fault,
    input logic             trap,
    input logic             wb_valid,
    input logic [PTR_W-1:0] wb_ptr,
    input logic [CNT_W-1:0] wb_cnt
);
    AST_TRAP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !busy && !$past(busy) && $past(start)); // R1

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_ptr == PTR_W'($past(wb_ptr) + 1'b1)); // R5

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_cnt == CNT_W'($past(wb_cnt) - 1'b1)); // R5

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && $past(busy)); // R6

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault, trap})); // R6

    AST_FAULT_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy && $past(busy) && $past(mem_ack)); // R7

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R10
endmodule

bind mbl_loader mbl_loader_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .done     (done),
    .fault    (fault),
    .trap     (trap),
    .wb_valid (wb_valid),
    .wb_ptr   (wb_ptr),
    .wb_cnt   (wb_cnt)
);

// File: tb/mbl_loader_tb.sv
module mbl_loader_tb_top;
    localparam int PTR_W = 16;
    localparam int CNT_W = 8;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       map_sel = '0;
    logic             opt_lock4 = 1'b1;
    logic             opt_wide = 1'b1;
    logic [PTR_W-1:0] ptr_in = '0;
    logic [IDX_W-1:0] idx_in = '0;
    logic [CNT_W-1:0] cnt_in = '0;
    logic             mem_req;
    logic [PTR_W-1:0] mem_addr;
    logic             mem_ack = 1'b0;
    logic [31:0]      mem_rdata = '0;
    logic             mem_err = 1'b0;
    logic             busy, done, fault, trap, wb_valid;
    logic [PTR_W-1:0] wb_ptr;
    logic [IDX_W-1:0] wb_idx;
    logic [CNT_W-1:0] wb_cnt;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [3:0]       rd_wlk;
    logic [1:0]       rd_acc;
    logic [10:0]      rd_rel;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] mem [256];
    bit          fault_en = 1'b0;
    logic [7:0]  fault_addr = '0;

    logic [3:0]  ref_wlk [32];
    logic [1:0]  ref_acc [32];
    logic [10:0] ref_rel [64];

    always #2.5 clk = ~clk;

    mbl_loader dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .map_sel(map_sel),
        .opt_lock4(opt_lock4), .opt_wide(opt_wide), .ptr_in(ptr_in),
        .idx_in(idx_in), .cnt_in(cnt_in), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_err(mem_err), .busy(busy), .done(done), .fault(fault),
        .trap(trap), .wb_valid(wb_valid), .wb_ptr(wb_ptr), .wb_idx(wb_idx),
        .wb_cnt(wb_cnt), .rd_idx(rd_idx), .rd_wlk(rd_wlk), .rd_acc(rd_acc),
        .rd_rel(rd_rel)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Memory responder: random latency, data from the bench image (R10)
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            mem_err = 1'b0;
            if (mem_req && ($urandom % 3 != 0)) begin
                mem_ack   = 1'b1;
                mem_rdata = mem[mem_addr[7:0]];
                mem_err   = fault_en && (mem_addr[7:0] == fault_addr);
            end
        end
    end

    function automatic logic [31:0] rotl(input logic [31:0] w, input int n);
        return (w << n) | (w >> (32 - n));
    endfunction

    task automatic cmp_tables(input string tag);
        for (int k = 0; k < 64; k++) begin
            rd_idx = IDX_W'(k);
            #0.1;
            if (k < 32) begin
                chk(rd_wlk == ref_wlk[k], {tag, " R2 R4 lock table"}, rd_wlk, ref_wlk[k]);
                chk(rd_acc == ref_acc[k], {tag, " R2 R4 access table"}, rd_acc, ref_acc[k]);
            end
            chk(rd_rel == ref_rel[k], {tag, " R2 R4 reloc table"}, rd_rel, ref_rel[k]);
        end
    endtask

    task automatic run_load(input int sel, input logic [15:0] p, input logic [5:0] i,
                            input logic [7:0] c, input bit fen, input logic [7:0] faddr,
                            input bit lock4, input bit wide, input bit glitch,
                            input string tag);
        bit          valid;
        int          width, depth, tgt, nwords, words_done;
        logic [10:0] dmask;
        logic [31:0] w;
        int          cs;
        bit          exp_fault;
        int          k, cyc;
        logic [15:0] ep;
        logic [7:0]  ec;

        valid = (sel == 1) || (sel == 2) || (sel == 4) ||
                (sel == 3 && lock4) || (sel == 5 && wide);
        width = 2; dmask = 11'h3; depth = 32; tgt = 0;
        case (sel)
            1: begin width = 2;  dmask = 11'h003; depth = 32; tgt = 0; end
            2: begin width = 2;  dmask = 11'h003; depth = 32; tgt = 1; end
            3: begin width = 4;  dmask = 11'h00F; depth = 32; tgt = 0; end
            4: begin width = 8;  dmask = 11'h0FF; depth = 64; tgt = 2; end
            5: begin width = 16; dmask = 11'h7FF; depth = 64; tgt = 2; end
            default: ;
        endcase
        cs = int'(i) % depth;
        nwords = (c == 0) ? 256 : int'(c);
        words_done = 0;
        exp_fault = 1'b0;
        if (valid) begin
            for (int wd = 0; wd < nwords; wd++) begin
                logic [15:0] a;
                a = p + 16'(wd);
                if (fen && a[7:0] == faddr) begin
                    exp_fault = 1'b1;
                    break;
                end
                w = mem[a[7:0]];
                for (int it = 0; it < 32 / width; it++) begin
                    w = rotl(w, width);
                    if (tgt == 0) ref_wlk[cs] = 4'(w[10:0] & dmask);
                    else if (tgt == 1) ref_acc[cs] = 2'(w[10:0] & dmask);
                    else ref_rel[cs] = w[10:0] & dmask;
                    cs = (cs + 1) % depth;
                end
                words_done++;
            end
        end

        @(negedge clk);
        opt_lock4 = lock4; opt_wide = wide;
        map_sel = 3'(sel); ptr_in = p; idx_in = i; cnt_in = c;
        fault_en = fen; fault_addr = faddr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; cyc = 0;
        forever begin
            if (wb_valid) begin
                ep = p + 16'(k + 1);
                ec = c - 8'(k + 1);
                chk(wb_ptr == ep, {tag, " R5 pointer step"}, wb_ptr, ep);
                chk(wb_cnt == ec, {tag, " R5 count step"}, wb_cnt, ec);
                k++;
            end
            if (done || fault || trap) break;
            if (cyc > 20000) begin
                chk(1'b0, {tag, " R6 load never ended"}, cyc, 0);
                break;
            end
            if (glitch && cyc == 3) begin
                start = 1'b1; map_sel = 3'd2; ptr_in = p + 16'd50; cnt_in = 8'd3;
                idx_in = 6'd7;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        fault_en = 1'b0;
        if (!valid) begin
            chk(trap == 1'b1, {tag, " R1 trap"}, trap, 1);
            chk(busy == 1'b0, {tag, " R1 not busy"}, busy, 0);
        end else if (exp_fault) begin
            chk(fault == 1'b1, {tag, " R7 fault"}, fault, 1);
            chk(busy == 1'b0, {tag, " R7 busy dropped"}, busy, 0);
        end else begin
            chk(done == 1'b1, {tag, " R6 done"}, done, 1);
            chk(busy == 1'b0, {tag, " R6 busy dropped"}, busy, 0);
        end
        if (valid) begin
            ep = p + 16'(words_done);
            ec = c - 8'(words_done);
            chk(k == words_done, {tag, " R5 write-back pulses"}, k, words_done);
            chk(wb_ptr == ep, {tag, " R7 final pointer"}, wb_ptr, ep);
            chk(wb_cnt == ec, {tag, " R7 final count"}, wb_cnt, ec);
            chk(wb_idx == 6'(cs), {tag, " R4 final index"}, wb_idx, cs);
        end
        @(negedge clk);
        cmp_tables(tag);
    endtask

    initial begin
        #200000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 256; k++) mem[k] = $urandom;
        mem[10] = 32'h1234_5678;
        mem[11] = 32'hABCD_1234;
        for (int k = 0; k < 32; k++) begin ref_wlk[k] = '0; ref_acc[k] = '0; end
        for (int k = 0; k < 64; k++) ref_rel[k] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && done == 0 && fault == 0 && trap == 0 && wb_valid == 0,
            "R9 reset outputs", {busy, done, fault, trap, wb_valid}, 0);
        chk(wb_ptr == 0 && wb_cnt == 0 && wb_idx == 0, "R9 reset write-back",
            wb_ptr, 0);
        cmp_tables("R9 reset");

        // R3 directed field order
        run_load(4, 16'd10, 6'd0, 8'd1, 0, 8'd0, 1, 1, 0, "R3 sel4");
        rd_idx = 6'd0; #0.1; chk(rd_rel == 11'h012, "R3 first field", rd_rel, 11'h012);
        rd_idx = 6'd3; #0.1; chk(rd_rel == 11'h078, "R3 last field", rd_rel, 11'h078);
        run_load(5, 16'd11, 6'd20, 8'd1, 0, 8'd0, 1, 1, 0, "R3 sel5");
        rd_idx = 6'd20; #0.1; chk(rd_rel == 11'h3CD, "R2 R3 wide mask", rd_rel, 11'h3CD);
        rd_idx = 6'd21; #0.1; chk(rd_rel == 11'h234, "R2 R3 wide second", rd_rel, 11'h234);

        // R1 refused selectors
        run_load(0, 16'd0, 6'd0, 8'd2, 0, 8'd0, 1, 1, 0, "R1 sel0");
        run_load(6, 16'd0, 6'd0, 8'd2, 0, 8'd0, 1, 1, 0, "R1 sel6");
        run_load(7, 16'd0, 6'd0, 8'd2, 0, 8'd0, 1, 1, 0, "R1 sel7");
        run_load(3, 16'd0, 6'd0, 8'd2, 0, 8'd0, 0, 1, 0, "R1 sel3 option off");
        run_load(5, 16'd0, 6'd0, 8'd2, 0, 8'd0, 1, 0, 0, "R1 sel5 option off");

        // R4 wrap and index masking
        run_load(1, 16'd30, 6'd31, 8'd2, 0, 8'd0, 1, 1, 0, "R4 lock wrap");
        run_load(2, 16'd40, 6'd45, 8'd1, 0, 8'd0, 1, 1, 0, "R4 index masked");
        run_load(5, 16'd50, 6'd63, 8'd2, 0, 8'd0, 1, 1, 0, "R4 reloc wrap");

        // R7 faults
        run_load(3, 16'd60, 6'd4, 8'd5, 1, 8'd62, 1, 1, 0, "R7 later word");
        run_load(4, 16'd70, 6'd9, 8'd3, 1, 8'd70, 1, 1, 0, "R7 first word");

        // R8 start while busy
        run_load(4, 16'd80, 6'd2, 8'd6, 0, 8'd0, 1, 1, 1, "R8 start ignored");

        // R6 full-range count
        run_load(4, 16'd100, 6'd5, 8'd0, 0, 8'd0, 1, 1, 0, "R6 count zero");

        // random mix
        for (int n = 0; n < 40; n++) begin
            int s;
            s = 1 + int'($urandom % 5);
            run_load(s, 16'($urandom % 240), 6'($urandom), 8'(1 + $urandom % 8),
                     ($urandom % 5) == 0, 8'($urandom), 1, 1, 0, "random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule